// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt events from up to 26 source lines and turns them into a single request and a vector address for a CPU. A rising edge on a source line latches a posted flag for that source. A per-source mask bit decides whether a posted flag counts as pending. A fixed-priority picker selects the pending source with the smallest index. It presents that source's vector, which is the index times four, together with a request that a global enable input gates.

Software reaches the block through a narrow write port. Each 8-bit register covers eight sources and either loads their mask bits or clears their posted flags. A separate strobe clears every posted flag at once. When the CPU accepts the request, it pulses a take input, and the posted flag of the source shown on the vector output is cleared. Several priority slots are reserved. Their inputs are ignored and they can never produce a request. Raising the global enable again during service lets a newly pending source interrupt at once, which gives nesting.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A rising edge on a non-reserved source input sets that source's posted flag. A level held high posts only once, and a later posting needs a new low-to-high edge.
- R2: A posted flag stays set until it is cleared. Writing a clear register clears the flags whose data bits are 1, and 0 bits leave their flags unchanged. A pulse on clr_all_i clears every posted flag.
- R3: A source with mask bit 0 never produces a request, but its flag still posts and stays posted. Setting the mask bit later makes that flag pending.
- R4: When several sources are pending, the source with the smallest index is selected.
- R5: irq_o is 1 exactly when at least one source is pending and gie_i was 1, and it is registered one clock after its inputs.
- R6: vec_o equals the selected index times 4, so index 5 gives 0x14 and index 25 gives 0x64. vec_o is 0 when nothing is pending. vec_o is registered and does not depend on gie_i.
- R7: The reserved slots 8 to 12, 19, 23 and 24 never post, never take a mask bit and never produce a request.
- R8: A take_i pulse while irq_o is 1 clears the posted flag of the source shown on vec_o. A take_i pulse while irq_o is 0 has no effect. If a new edge and a clear reach the same flag in the same cycle, the flag stays set.
- R9: reg_addr_i[2] selects the register kind, with 0 for mask and 1 for clear. reg_addr_i[1:0] selects group g, and data bit j of that register maps to source 8g+j.
- R10: A synchronous active-high rst clears all posted flags and all mask bits and drives irq_o and vec_o to 0.
- R11: When gie_i rises while a source is pending, irq_o rises on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 26 | Interrupt source lines, edge detected |
| gie_i | input | 1 | Global interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Bit 2 selects mask (0) or clear (1); bits 1:0 select the group |
| reg_wdata_i | input | 8 | Register write data |
| clr_all_i | input | 1 | Clears every posted flag |
| take_i | input | 1 | CPU accepts the current request |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the selected source |

## Verification
A source edge, a clear write, a clear-all pulse or a take pulse appears on irq_o and vec_o two clocks after it is driven. The posted flag is registered first and the outputs are registered on the next clock. A change on gie_i shows on irq_o one clock later. The driver records each expected result with the exact cycle on which it becomes due. The monitor compares that result on the falling edge of that cycle. For register writes, the driver waits out the write cycle and then schedules the expectation one clock ahead.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned VEC_SHIFT  = 2;

    typedef enum logic {
        REG_MASK  = 1'b0,
        REG_CLEAR = 1'b1
    } reg_kind_e;
endpackage

// File: rtl/irq_post_bank.sv
module irq_post_bank #(
    parameter int unsigned NUM_SRC = 26,
    parameter logic [NUM_SRC-1:0] RSV_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] posted_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] posted;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_SRC-1:0] rise_d;

    always_comb begin
        st_d        = st_q;
        rise_d      = src_i & ~st_q.prev & ~RSV_MASK;
        st_d.prev   = src_i;
        // a new edge outranks any clear in the same cycle
        st_d.posted = (st_q.posted & ~clr_i) | rise_d;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign posted_o = st_q.posted;

    // R1 / R8: every detected edge is visible as posted on the next clock
    a_r1_edge_posts: assert property (@(posedge clk) disable iff (rst)
        (rise_d != '0) |=> ((st_q.posted & $past(rise_d)) == $past(rise_d)));

    // R7: reserved slots never hold a posted flag
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q.posted & RSV_MASK) == '0);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_SRC = 26,
    parameter int unsigned IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 26,
    parameter int unsigned VEC_W    = 16,
    parameter logic [NUM_SRC-1:0] RSV_MASK = 26'h1881F00,
    localparam int unsigned NUM_GRP = (NUM_SRC + REG_W - 1) / REG_W,
    localparam int unsigned GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int unsigned ADDR_W  = GRP_W + 1,
    localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               gie_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    input  logic               clr_all_i,
    input  logic               take_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               irq;
        logic [IDX_W-1:0]   idx;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [NUM_SRC-1:0] posted;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] clr_wr;
    logic [NUM_SRC-1:0] take_vec;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    reg_kind_e          wr_kind;
    logic [GRP_W-1:0]   wr_grp;

    assign wr_kind = reg_kind_e'(reg_addr_i[ADDR_W-1]);
    assign wr_grp  = reg_addr_i[GRP_W-1:0];

    // clear sources: register write, clear-all strobe, CPU take
    always_comb begin
        clr_wr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_we_i && wr_kind == REG_CLEAR && wr_grp == GRP_W'(i / REG_W))
                clr_wr[i] = reg_wdata_i[i % REG_W];
        end
        take_vec = (take_i && st_q.irq) ? (NUM_SRC'(1) << st_q.idx) : '0;
        clr_vec  = clr_wr | {NUM_SRC{clr_all_i}} | take_vec;
    end

    irq_post_bank #(
        .NUM_SRC  (NUM_SRC),
        .RSV_MASK (RSV_MASK)
    ) bank_i (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_i),
        .clr_i    (clr_vec),
        .posted_o (posted)
    );

    assign pending = posted & st_q.mask;

    irq_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) pick_i (
        .req_i (pending),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_we_i && wr_kind == REG_MASK && wr_grp == GRP_W'(i / REG_W))
                st_d.mask[i] = reg_wdata_i[i % REG_W];
        end
        st_d.mask = st_d.mask & ~RSV_MASK;
        st_d.irq  = pick_any & gie_i;
        st_d.idx  = pick_any ? pick_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq_o = st_q.irq;
    assign vec_o = VEC_W'({st_q.idx, {VEC_SHIFT{1'b0}}});

    // R5: a request needs the global enable one clock earlier
    a_r5_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(gie_i));

    // R11: enable plus pending gives a request on the next clock
    a_r11_prompt_request: assert property (@(posedge clk) disable iff (rst)
        (gie_i && pending != '0) |=> irq_o);

    // R4: the picked source is pending and no lower index is pending
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        pick_any |-> (pending[pick_idx] &&
            ((pending & ((NUM_SRC'(1) << pick_idx) - NUM_SRC'(1))) == '0)));

    // R3: a posted flag only drops when some clear reached it
    a_r3_mask_keeps_post: assert property (@(posedge clk) disable iff (rst)
        ($past(posted) & ~posted & ~$past(clr_vec)) == '0);

    // R6: vector is word aligned and inside the slot range
    a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
        (vec_o[VEC_SHIFT-1:0] == '0) && (vec_o <= VEC_W'((NUM_SRC - 1) * 4)));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb_top;
    localparam int NSRC = 26;
    localparam logic [NSRC-1:0] RSV = 26'h1881F00;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic            gie = 1'b0;
    logic            we = 1'b0;
    logic [2:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic            clr_all = 1'b0;
    logic            take = 1'b0;
    logic            irq;
    logic [15:0]     vec;

    irq_vec_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .gie_i       (gie),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .clr_all_i   (clr_all),
        .take_i      (take),
        .irq_o       (irq),
        .vec_o       (vec)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          due;
        logic        irq;
        logic [15:0] vec;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every item due on this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (irq !== e.irq || vec !== e.vec) begin
                fails++;
                $display("FAIL %s: irq=%0b vec=%h expected irq=%0b vec=%h",
                         e.tag, irq, vec, e.irq, e.vec);
            end
        end
    end

    task automatic expect_at(int lat, logic eirq, logic [15:0] evec, string tag);
        exp_t e;
        e.due = cyc + lat;
        e.irq = eirq;
        e.vec = evec;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit kind, int grp, logic [7:0] d);
        we    = 1'b1;
        addr  = {kind, 2'(grp)};
        wdata = d;
        tick(1);
        we    = 1'b0;
    endtask

    task automatic pulse(int i, logic eirq, logic [15:0] evec, string tag);
        src[i] = 1'b1;
        expect_at(2, eirq, evec, tag);
        tick(1);
        src[i] = 1'b0;
        tick(1);
    endtask

    task automatic strobe_take(logic eirq, logic [15:0] evec, string tag);
        take = 1'b1;
        expect_at(2, eirq, evec, tag);
        tick(1);
        take = 1'b0;
        tick(1);
    endtask

    task automatic strobe_clr_all(string tag);
        clr_all = 1'b1;
        expect_at(2, 1'b0, 16'h0, tag);
        tick(1);
        clr_all = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        expect_at(1, 0, 16'h0, "R10 outputs after reset");
        tick(1);
        for (int g = 0; g < 4; g++) wr(1'b0, g, 8'hFF);
        expect_at(1, 0, 16'h0, "R10 no posted flag after reset");
        tick(1);
        gie = 1'b1;
        expect_at(1, 0, 16'h0, "R5 nothing pending");
        tick(1);

        pulse(5, 1, 16'h0014, "R1 R6 source 5 posts");
        pulse(2, 1, 16'h0008, "R4 source 2 outranks 5");
        wr(1'b1, 0, 8'h04);
        expect_at(1, 1, 16'h0014, "R2 R9 clear bit 2 of group 0");
        tick(1);
        wr(1'b1, 0, 8'h00);
        expect_at(1, 1, 16'h0014, "R2 zero clear write ignored");
        tick(1);
        gie = 1'b0;
        expect_at(1, 0, 16'h0014, "R5 R6 enable low gates request only");
        tick(1);
        gie = 1'b1;
        expect_at(1, 1, 16'h0014, "R11 enable raised with pending");
        tick(1);
        strobe_take(0, 16'h0, "R8 take clears source 5");

        src[7] = 1'b1;
        expect_at(2, 1, 16'h001C, "R1 held level posts");
        tick(2);
        strobe_take(0, 16'h0, "R8 take clears source 7");
        expect_at(3, 0, 16'h0, "R1 held level posts once");
        tick(3);
        src[7] = 1'b0;
        tick(1);

        wr(1'b0, 0, 8'hDF);
        expect_at(1, 0, 16'h0, "R9 mask write group 0");
        tick(1);
        pulse(5, 0, 16'h0, "R3 masked source gives no request");
        wr(1'b0, 0, 8'hFF);
        expect_at(1, 1, 16'h0014, "R3 posting kept while masked");
        tick(1);
        strobe_clr_all("R2 clear all");

        src = RSV;
        expect_at(2, 0, 16'h0, "R7 reserved slots silent");
        tick(1);
        src = '0;
        tick(1);
        pulse(25, 1, 16'h0064, "R6 slot 25 vector");
        pulse(13, 1, 16'h0034, "R4 slot 13 over slot 25");
        strobe_clr_all("R2 clear all second");

        src[3] = 1'b1;
        expect_at(2, 1, 16'h000C, "R8 source 3 posted");
        tick(2);
        src[3] = 1'b0;
        tick(1);
        src[3] = 1'b1;
        take = 1'b1;
        expect_at(2, 1, 16'h000C, "R8 posting wins over take");
        tick(1);
        take = 1'b0;
        tick(1);
        strobe_take(0, 16'h0, "R8 take after collision");
        src[3] = 1'b0;
        tick(1);

        gie = 1'b0;
        pulse(0, 0, 16'h0, "R5 source 0 pending with enable low");
        take = 1'b1;
        tick(1);
        take = 1'b0;
        gie = 1'b1;
        expect_at(1, 1, 16'h0, "R8 take without request ignored");
        tick(1);
        strobe_clr_all("R2 clear all third");

        wr(1'b0, 2, 8'hFD);
        expect_at(1, 0, 16'h0, "R9 mask write group 2");
        tick(1);
        pulse(17, 0, 16'h0, "R3 source 17 masked");
        wr(1'b1, 2, 8'h02);
        tick(1);
        wr(1'b0, 2, 8'hFF);
        expect_at(1, 0, 16'h0, "R9 group 2 clear reached source 17");
        tick(1);
        pulse(17, 1, 16'h0044, "R9 group 2 bit 1 is source 17");

        rst = 1'b1;
        expect_at(1, 0, 16'h0, "R10 reset during activity");
        tick(2);
        rst = 1'b0;
        tick(1);
        pulse(20, 0, 16'h0, "R10 masks cleared by reset");
        tick(2);
        done = 1'b1;
    end

    initial begin
        int waited = 0;
        while (!done && waited < 20000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule